// File: doc/BRIEF.md
# Debug Register Access Controller

This controller sits between privileged register-move operations and a bank of debug registers: four breakpoint address registers, a status register and a control register, reached through a 3-bit index. Indices 4 and 5 are aliases. With the debug-extensions mode bit clear they reach the status and control registers. With the mode bit set they fault as an invalid opcode.

Every request is answered in the same cycle. The answer carries read data and a 2-bit fault code. The controller checks faults in a fixed priority order. It enforces the fixed-one bits of the status and control registers. It also implements the general-detect trap, which blocks one access and records it in the status register.

When a write changes what the breakpoint matcher has to track, a per-slot refresh pulse tells the matcher. This happens on a write to an active address register, and on a control write that changes the enable state of a slot or any field outside the enable byte. Address comparison itself happens elsewhere.

Top module: `dbg_reg_ctrl`

## Requirements
- R1: After reset the address registers read 0, the status register reads 0xFFFF0FF0 and the control register reads 0x00000400. With no request valid, the fault code is 0 and no refresh bit is set.
- R2: When the mode bit is set, an access to index 4 or 5 returns fault code 1 (invalid opcode) with read data 0, and changes no register.
- R3: When the mode bit is clear, index 4 acts as index 6 (status) and index 5 acts as index 7 (control), for both reads and writes.
- R4: When control bit 13 (general detect) is set, any access returns fault code 3 (debug) with read data 0. The access is not performed. Control bit 13 is cleared and status bit 13 is set.
- R5: A write to the status register with bit 12 set, or to the control register with any of bits 11, 12, 14 or 15 set, returns fault code 2 (general protection) and stores nothing.
- R6: A successful status write stores the written value OR 0xFFFF0FF0.
- R7: A successful control write stores the written value OR 0x00000400.
- R8: A successful control write that differs from the old value only in bits [7:0] sets `slot_refresh[i]` only for the slots whose combined enable, bit 2i OR bit 2i+1, changed.
- R9: A successful control write that differs from the old value anywhere outside bits [7:0] sets all four `slot_refresh` bits.
- R10: A successful write to address register i sets `slot_refresh[i]` only when slot i is enabled and its type field, control bits [17+4i:16+4i], is not 2'b10 (I/O).
- R11: `rsp_ack` equals `req_valid` in the same cycle. Fault code, read data and refresh pulses are valid in that cycle, and a faulting access raises no refresh bit.
- R12: Faults are checked in this order: invalid opcode first, then general detect, then reserved bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 3 | Debug register index 0..7 |
| req_wdata | input | XLEN | Write data |
| ext_mode | input | 1 | Debug-extensions mode; makes indices 4 and 5 fault |
| rsp_ack | output | 1 | Request acknowledge, same cycle |
| rsp_fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection, 3 debug |
| rsp_rdata | output | XLEN | Read data, 0 on a write or a fault |
| slot_refresh | output | 4 | Per-slot notification to the breakpoint matcher |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, the fixed-one and reserved masks listed above, and bit 13 for both general detect and the status flag. With these values the bench can reach every fault code, and both the enable-only and the full-change paths of a control write. It can also reach an I/O-typed slot, which must not refresh on an address write. A general-detect trap is armed while another fault is also pending, which exercises the priority order.

// File: rtl/dbg_reg_ctrl.sv
module dbg_reg_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] STAT_FIX  = 'hFFFF_0FF0,
  parameter logic [XLEN-1:0] CTRL_FIX  = 'h0000_0400,
  parameter logic [XLEN-1:0] STAT_RSVD = 'h0000_1000,
  parameter logic [XLEN-1:0] CTRL_RSVD = 'h0000_D800,
  parameter int GD_BIT = 13,
  parameter int BD_BIT = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2:0]      req_index,
  input  logic [XLEN-1:0] req_wdata,
  input  logic            ext_mode,
  output logic            rsp_ack,
  output logic [1:0]      rsp_fault,
  output logic [XLEN-1:0] rsp_rdata,
  output logic [3:0]      slot_refresh
);
  localparam int NSLOT = 4;
  localparam int TYPE_LSB = 16;
  localparam logic [XLEN-1:0] ENB_MASK = XLEN'(8'hFF);
  localparam logic [1:0] F_NONE = 2'd0, F_UD = 2'd1, F_GP = 2'd2, F_DB = 2'd3;

  logic [XLEN-1:0] addr_q [NSLOT];
  logic [XLEN-1:0] stat_q, ctrl_q;

  logic is_alias, ud, gd, gp, ok, rsvd_hit, enb_only;
  logic [2:0] eff;
  logic [XLEN-1:0] ctrl_new;
  logic [NSLOT-1:0] ctl_ref, adr_ref;

  assign is_alias = (req_index[2:1] == 2'b10);
  assign eff      = is_alias ? {2'b11, req_index[0]} : req_index;
  assign rsvd_hit = req_write && eff[2] &&
                    (eff[0] ? |(req_wdata & CTRL_RSVD) : |(req_wdata & STAT_RSVD));

  assign ud = req_valid && is_alias && ext_mode;
  assign gd = req_valid && !ud && ctrl_q[GD_BIT];
  assign gp = req_valid && !ud && !gd && rsvd_hit;
  assign ok = req_valid && !ud && !gd && !gp;

  assign rsp_ack   = req_valid;
  assign rsp_fault = ud ? F_UD : gd ? F_DB : gp ? F_GP : F_NONE;

  assign ctrl_new = req_wdata | CTRL_FIX;
  assign enb_only = ((ctrl_q ^ ctrl_new) & ~ENB_MASK) == '0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic old_en, new_en;
    assign old_en     = |ctrl_q[2*i +: 2];
    assign new_en     = |ctrl_new[2*i +: 2];
    assign ctl_ref[i] = enb_only ? (old_en != new_en) : 1'b1;
    assign adr_ref[i] = old_en && (ctrl_q[TYPE_LSB+4*i +: 2] != 2'b10);
    assign slot_refresh[i] = ok && req_write &&
                             ((eff == 3'd7 && ctl_ref[i]) ||
                              (eff == 3'(i) && adr_ref[i]));
  end

  always_comb begin
    rsp_rdata = '0;
    if (ok && !req_write) begin
      case (eff)
        3'd6:    rsp_rdata = stat_q;
        3'd7:    rsp_rdata = ctrl_q;
        3'd0, 3'd1, 3'd2, 3'd3:
                 rsp_rdata = addr_q[eff[1:0]];
        default: rsp_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) addr_q[i] <= '0;
      stat_q <= STAT_FIX;
      ctrl_q <= CTRL_FIX;
    end else if (gd) begin
      ctrl_q[GD_BIT] <= 1'b0;
      stat_q[BD_BIT] <= 1'b1;
    end else if (ok && req_write) begin
      if (!eff[2])          addr_q[eff[1:0]] <= req_wdata;
      else if (eff == 3'd6) stat_q <= req_wdata | STAT_FIX;
      else if (eff == 3'd7) ctrl_q <= ctrl_new;
    end
  end
endmodule

// File: rtl/dbg_reg_ctrl_chk.sv
module dbg_reg_ctrl_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] STAT_FIX = 'hFFFF_0FF0,
  parameter logic [XLEN-1:0] CTRL_FIX = 'h0000_0400,
  parameter int GD_BIT = 13,
  parameter int BD_BIT = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            rsp_ack,
  input logic [1:0]      rsp_fault,
  input logic [3:0]      slot_refresh,
  input logic [XLEN-1:0] stat_q,
  input logic [XLEN-1:0] ctrl_q
);
  // R2
  ud_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_fault == 2'd1) |=> ($stable(ctrl_q) && $stable(stat_q)));

  // R4
  gd_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_fault == 2'd3) |=> (!ctrl_q[GD_BIT] && stat_q[BD_BIT]));

  // R5
  gp_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_fault == 2'd2) |=> ($stable(ctrl_q) && $stable(stat_q)));

  // R6
  stat_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & STAT_FIX) == STAT_FIX);

  // R7
  ctrl_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & CTRL_FIX) == CTRL_FIX);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (rsp_fault == 2'd0 && slot_refresh == 4'd0 && !rsp_ack));

  // R11
  fault_no_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (slot_refresh == 4'd0));
endmodule

bind dbg_reg_ctrl dbg_reg_ctrl_chk #(
  .XLEN(XLEN), .STAT_FIX(STAT_FIX), .CTRL_FIX(CTRL_FIX),
  .GD_BIT(GD_BIT), .BD_BIT(BD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ack(rsp_ack),
  .rsp_fault(rsp_fault), .slot_refresh(slot_refresh),
  .stat_q(stat_q), .ctrl_q(ctrl_q)
);

// File: tb/test_dbg_reg_ctrl.sv
`timescale 1ns/1ps
module test_dbg_reg_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ext_mode = 1'b0;
  logic [2:0] req_index = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ack;
  logic [1:0] rsp_fault;
  logic [31:0] rsp_rdata;
  logic [3:0] slot_refresh;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_reg_ctrl i_dbg_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .ext_mode(ext_mode),
    .rsp_ack(rsp_ack), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
    .slot_refresh(slot_refresh));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  logic [1:0] f;
  logic [31:0] rd;
  logic [3:0] rf;

  task automatic acc(input logic w, input logic [2:0] idx, input logic [31:0] d, input logic ext);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_index = idx; req_wdata = d; ext_mode = ext;
    #1;
    f = rsp_fault; rd = rsp_rdata; rf = slot_refresh;
    chk("R11 ack", 32'(rsp_ack), 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; ext_mode = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 idle fault", 32'(rsp_fault), 0);
    chk("R1 idle refresh", 32'(slot_refresh), 0);
    chk("R11 idle ack", 32'(rsp_ack), 0);
    for (int i = 0; i < 4; i++) begin
      acc(0, 3'(i), 0, 0); chk("R1 addr", rd, 0);
    end
    acc(0, 6, 0, 0); chk("R1 status", rd, 32'hFFFF0FF0);
    acc(0, 7, 0, 0); chk("R1 control", rd, 32'h400);
  endtask

  task automatic t_status;
    acc(1, 6, 32'h1, 0);    chk("R6 fault", 32'(f), 0);
    acc(0, 6, 0, 0);        chk("R6 status", rd, 32'hFFFF0FF1);
    acc(1, 6, 32'h1000, 0); chk("R5 status gp", 32'(f), 2);
    acc(0, 6, 0, 0);        chk("R5 status kept", rd, 32'hFFFF0FF1);
    acc(1, 7, 32'h800, 0);  chk("R5 ctrl gp", 32'(f), 2);
    chk("R11 gp no refresh", 32'(rf), 0);
    acc(0, 7, 0, 0);        chk("R5 ctrl kept", rd, 32'h400);
  endtask

  task automatic t_ctrl;
    acc(1, 7, 32'h0, 0); chk("R8 no change refresh", 32'(rf), 0);
    acc(0, 7, 0, 0);     chk("R7 fixed one", rd, 32'h400);
  endtask

  task automatic t_alias_ud;
    acc(0, 4, 0, 1);   chk("R2 read ud", 32'(f), 1); chk("R2 rdata", rd, 0);
    acc(1, 5, 3, 1);   chk("R2 write ud", 32'(f), 1); chk("R2 refresh", 32'(rf), 0);
    acc(0, 7, 0, 0);   chk("R2 ctrl unchanged", rd, 32'h400);
  endtask

  task automatic t_alias_map;
    acc(1, 5, 32'h1, 0); chk("R3 write fault", 32'(f), 0); chk("R8 slot0", 32'(rf), 4'b0001);
    acc(0, 4, 0, 0);     chk("R3 alias status", rd, 32'hFFFF0FF1);
    acc(0, 7, 0, 0);     chk("R3 alias ctrl", rd, 32'h401);
  endtask

  task automatic t_enable_only;
    acc(1, 7, 32'h403, 0); chk("R8 same combined", 32'(rf), 0);
    acc(1, 7, 32'h40C, 0); chk("R8 swap slots", 32'(rf), 4'b0011);
  endtask

  task automatic t_full;
    acc(1, 7, 32'h0003_040C, 0); chk("R9 type change", 32'(rf), 4'b1111);
  endtask

  task automatic t_addr;
    acc(1, 1, 32'hABCD, 0);      chk("R10 enabled slot", 32'(rf), 4'b0010);
    acc(1, 0, 32'h55, 0);        chk("R10 disabled slot", 32'(rf), 0);
    acc(1, 7, 32'h0020_040C, 0); chk("R9 io type", 32'(rf), 4'b1111);
    acc(1, 1, 32'h77, 0);        chk("R10 io slot", 32'(rf), 0);
    acc(0, 1, 0, 0);             chk("R10 addr1", rd, 32'h77);
    acc(0, 0, 0, 0);             chk("R10 addr0", rd, 32'h55);
  endtask

  task automatic t_gd;
    acc(1, 7, 32'h2400, 0);   chk("R4 arm", 32'(f), 0);
    acc(0, 7, 0, 0);          chk("R4 trap", 32'(f), 3); chk("R4 rdata", rd, 0);
    acc(0, 7, 0, 0);          chk("R4 cleared", rd, 32'h400);
    acc(0, 6, 0, 0);          chk("R4 status flag", rd & 32'h2000, 32'h2000);
    acc(1, 7, 32'h2400, 0);
    acc(1, 0, 32'h1234, 0);   chk("R4 write trap", 32'(f), 3); chk("R4 no refresh", 32'(rf), 0);
    acc(0, 0, 0, 0);          chk("R4 not written", rd, 32'h55);
  endtask

  task automatic t_prio;
    acc(1, 7, 32'h2400, 0);
    acc(0, 4, 0, 1);        chk("R12 ud first", 32'(f), 1);
    acc(1, 7, 32'h800, 0);  chk("R12 gd before gp", 32'(f), 3);
    acc(0, 7, 0, 0);        chk("R12 ctrl after", rd, 32'h400);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_status();
    t_ctrl();
    t_alias_ud();
    t_alias_map();
    t_enable_only();
    t_full();
    t_addr();
    t_gd();
    t_prio();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule